// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block turns one software-level cache maintenance request into the sequence of commands that a range engine can execute. A request names a byte range by its first byte and an exclusive end byte, plus an operation: invalidate, clean, or flush (clean followed by invalidate). The block rounds the range to cache lines. It cuts the range into chunks that never exceed a fixed byte budget and never cross a page. It then emits each chunk as a command carrying the inclusive first and last line addresses.

For invalidation, lines that the range covers only partly are not simply discarded. Each such line gets a single-line clean-and-invalidate command, and only the fully covered lines are invalidated as ranges. A write-through override input tells the block that the cache never holds dirty data. Clean work is then skipped. A clean request issues nothing, and a flush issues only its invalidates. Commands leave on a valid/ready stream. A one-cycle done pulse marks the end of each request.

Top module: `rsplit_top`

## Requirements
- R1: Every command carries line-aligned addresses. A range command (kind 1 = range clean, kind 2 = range invalidate) names the first line of its chunk and, as its inclusive last line, the chunk end minus 32 bytes. A single-line command (kind 0 = clean-and-invalidate one line) has first equal to last.
- R2: No range command spans more than 1024 bytes, that is, last minus first is at most 992.
- R3: No command spans a 4096-byte page boundary. A chunk end is clipped to the start of the next page.
- R4: For invalidate (op code 0), a start address that is not a multiple of 32 first produces a kind 0 command on the line containing the start. Range work then begins at the next line boundary.
- R5: For invalidate, if the rounded-up start is still below the end and the end is not a multiple of 32, a kind 0 command on the line containing the end follows the head command. Range work then stops at the end rounded down.
- R6: For clean (op code 1) and flush (op code 2, and code 3 which acts as flush), the start is rounded down and the end rounded up to 32-byte lines before chunking. No single-line commands are issued.
- R7: For flush without override, each chunk produces a range clean immediately followed by a range invalidate with the same first and last addresses.
- R8: With the write-through override sampled high at acceptance, a clean request issues no command, and a flush issues only range invalidates.
- R9: done is high for exactly one cycle. That cycle is the one right after the handshake of the request's last command, or right after acceptance when the request issues nothing. A request whose start equals its end issues nothing.
- R10: req_ready is high only while the block is idle, so it drops the cycle after a request is accepted. A command that is held valid without ready keeps its kind and addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| req_wt | input | 1 | Write-through override, sampled with the request |
| req_start | input | AW | First byte of the range |
| req_end | input | AW | Exclusive end byte of the range |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_kind | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmd_first | output | AW | Inclusive first line address |
| cmd_last | output | AW | Inclusive last line address |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The first command of a request appears one cycle after acceptance, because the accept edge loads the state register that drives the command outputs. Each later command appears one cycle after the previous handshake, and done is due one cycle after the final handshake, or one cycle after acceptance for an empty request. The bench drives inputs and samples outputs at the falling edge. It records a command in the half-cycle before the rising edge that completes its handshake, and it demands done in exactly the following sample slot and in no other. Backpressure patterns stretch these gaps, and the bench compares the held command against its value from the previous sample.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        K_LINE_CI = 2'd0,
        K_RCLEAN  = 2'd1,
        K_RINV    = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_TAIL,
        S_RCLEAN,
        S_RINV,
        S_FIN
    } state_e;

endpackage

// File: rtl/rsplit_align.sv
// Rounds an incoming byte range to lines according to the operation.
module rsplit_align #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  rsplit_pkg::op_e  op,
    input  logic [AW-1:0]    start_b,
    input  logic [AW-1:0]    end_b,
    output logic [AW:0]      work_start,
    output logic [AW:0]      work_end,
    output logic             head_need,
    output logic             tail_need,
    output logic [AW-1:0]    head_line
);
    import rsplit_pkg::*;

    localparam int XW = AW + 1;
    localparam int LB = $clog2(LINE_BYTES);
    localparam logic [XW-1:0] LINE_X = XW'(LINE_BYTES);

    logic [AW-1:0] start_dn;
    logic [AW-1:0] end_dn;
    logic          start_part;
    logic          end_part;
    logic [XW-1:0] start_up;
    logic [XW-1:0] end_up;

    always_comb begin
        start_dn   = {start_b[AW-1:LB], {LB{1'b0}}};
        end_dn     = {end_b[AW-1:LB], {LB{1'b0}}};
        start_part = |start_b[LB-1:0];
        end_part   = |end_b[LB-1:0];
        start_up   = start_part ? ({1'b0, start_dn} + LINE_X) : {1'b0, start_b};
        end_up     = end_part ? ({1'b0, end_dn} + LINE_X) : {1'b0, end_b};
        head_line  = start_dn;

        if (op == OP_INV) begin
            head_need  = start_part;
            work_start = start_up;
            tail_need  = (start_up < {1'b0, end_b}) && end_part;
            work_end   = tail_need ? {1'b0, end_dn} : {1'b0, end_b};
        end else begin
            head_need  = 1'b0;
            tail_need  = 1'b0;
            work_start = {1'b0, start_dn};
            work_end   = end_up;
        end
    end

endmodule

// File: rtl/rsplit_chunk.sv
// End of the chunk that begins at cur: clipped by the range end,
// the byte budget and the next page start.
module rsplit_chunk #(
    parameter int AW         = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BYTES  = 1024
) (
    input  logic [AW:0] cur,
    input  logic [AW:0] lim,
    output logic [AW:0] chunk_end
);
    localparam int XW = AW + 1;
    localparam int PB = $clog2(PAGE_BYTES);
    localparam logic [XW-1:0] MAX_X  = XW'(MAX_BYTES);
    localparam logic [XW-1:0] PAGE_X = XW'(PAGE_BYTES);

    logic [XW-1:0] by_budget;
    logic [XW-1:0] by_page;
    logic [XW-1:0] tighter;

    always_comb begin
        by_budget = cur + MAX_X;
        by_page   = {cur[XW-1:PB], {PB{1'b0}}} + PAGE_X;
        tighter   = (by_budget < by_page) ? by_budget : by_page;
        chunk_end = (lim < tighter) ? lim : tighter;
    end

endmodule

// File: rtl/rsplit_top.sv
module rsplit_top #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BYTES  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_wt,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_first,
    output logic [AW-1:0] cmd_last,
    output logic          done
);
    import rsplit_pkg::*;

    localparam int XW = AW + 1;
    localparam int LB = $clog2(LINE_BYTES);
    localparam int PB = $clog2(PAGE_BYTES);
    localparam logic [XW-1:0] LINE_X = XW'(LINE_BYTES);

    typedef struct packed {
        state_e        st;
        op_e           op;
        logic          wt;
        logic          tail;
        logic [XW-1:0] cur;
        logic [XW-1:0] lim;
        logic [AW-1:0] head_line;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    op_e           op_in;
    logic [XW-1:0] al_start;
    logic [XW-1:0] al_end;
    logic          al_head;
    logic          al_tail;
    logic [AW-1:0] al_head_line;
    logic [XW-1:0] ce;
    logic [XW-1:0] ce_last;

    assign op_in = (req_op == 2'd0) ? OP_INV : (req_op == 2'd1) ? OP_CLEAN : OP_FLUSH;

    rsplit_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
        .op         (op_in),
        .start_b    (req_start),
        .end_b      (req_end),
        .work_start (al_start),
        .work_end   (al_end),
        .head_need  (al_head),
        .tail_need  (al_tail),
        .head_line  (al_head_line)
    );

    rsplit_chunk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .MAX_BYTES(MAX_BYTES)) u_chunk (
        .cur       (ctx_q.cur),
        .lim       (ctx_q.lim),
        .chunk_end (ce)
    );

    // First range state for a window, or finish when it is empty.
    function automatic state_e range_entry(logic [XW-1:0] s, logic [XW-1:0] e, op_e op, logic wt);
        if (s >= e)                 return S_FIN;
        else if (op == OP_INV || wt) return S_RINV;
        else                        return S_RCLEAN;
    endfunction

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    ctx_d.op        = op_in;
                    ctx_d.wt        = req_wt;
                    ctx_d.cur       = al_start;
                    ctx_d.lim       = al_end;
                    ctx_d.tail      = al_tail;
                    ctx_d.head_line = al_head_line;
                    if (req_start == req_end)
                        ctx_d.st = S_FIN;
                    else if (op_in == OP_INV && al_head)
                        ctx_d.st = S_HEAD;
                    else if (op_in == OP_INV && al_tail)
                        ctx_d.st = S_TAIL;
                    else if (op_in == OP_CLEAN && req_wt)
                        ctx_d.st = S_FIN;
                    else
                        ctx_d.st = range_entry(al_start, al_end, op_in, req_wt);
                end
            end
            S_HEAD: begin
                if (cmd_ready)
                    ctx_d.st = ctx_q.tail ? S_TAIL
                             : range_entry(ctx_q.cur, ctx_q.lim, ctx_q.op, ctx_q.wt);
            end
            S_TAIL: begin
                if (cmd_ready)
                    ctx_d.st = range_entry(ctx_q.cur, ctx_q.lim, ctx_q.op, ctx_q.wt);
            end
            S_RCLEAN: begin
                if (cmd_ready) begin
                    if (ctx_q.op == OP_FLUSH) begin
                        ctx_d.st = S_RINV;
                    end else begin
                        ctx_d.cur = ce;
                        ctx_d.st  = (ce < ctx_q.lim) ? S_RCLEAN : S_FIN;
                    end
                end
            end
            S_RINV: begin
                if (cmd_ready) begin
                    ctx_d.cur = ce;
                    if (ce < ctx_q.lim)
                        ctx_d.st = (ctx_q.op == OP_FLUSH && !ctx_q.wt) ? S_RCLEAN : S_RINV;
                    else
                        ctx_d.st = S_FIN;
                end
            end
            S_FIN:   ctx_d.st = S_IDLE;
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, op: OP_INV, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // Output decode from registered state only.
    always_comb begin
        ce_last   = ce - LINE_X;
        req_ready = (ctx_q.st == S_IDLE);
        done      = (ctx_q.st == S_FIN);
        cmd_valid = 1'b0;
        cmd_kind  = K_LINE_CI;
        cmd_first = ctx_q.cur[AW-1:0];
        cmd_last  = ce_last[AW-1:0];
        case (ctx_q.st)
            S_HEAD: begin
                cmd_valid = 1'b1;
                cmd_first = ctx_q.head_line;
                cmd_last  = ctx_q.head_line;
            end
            S_TAIL: begin
                cmd_valid = 1'b1;
                cmd_first = ctx_q.lim[AW-1:0];
                cmd_last  = ctx_q.lim[AW-1:0];
            end
            S_RCLEAN: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_RCLEAN;
            end
            S_RINV: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_RINV;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_first[LB-1:0] == '0) && (cmd_last[LB-1:0] == '0) && (cmd_last >= cmd_first));

    assert_chunk_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_last} - {1'b0, cmd_first}) < XW'(MAX_BYTES));

    assert_same_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_first[AW-1:PB] == cmd_last[AW-1:PB]));

    assert_flush_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_kind == K_RCLEAN && ctx_q.op == OP_FLUSH)
        |=> cmd_valid && cmd_kind == K_RINV && cmd_first == $past(cmd_first) && cmd_last == $past(cmd_last));

    assert_wt_no_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ctx_q.wt) |-> (cmd_kind != K_RCLEAN));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_first) && $stable(cmd_last));

endmodule

// File: tb/sim_rsplit_top.sv
`timescale 1ns/1ps
module sim_rsplit_top;

    localparam int AW = 32;
    localparam int NV = 12;
    localparam int MAXC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic          req_wt = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_first;
    logic [AW-1:0] cmd_last;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rsplit_top #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_wt(req_wt),
        .req_start(req_start), .req_end(req_end),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_first(cmd_first), .cmd_last(cmd_last), .done(done)
    );

    // Vector fields: op(2) wt(1) backpressure(1) start(32) end(32) expected count(8)
    localparam logic [75:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h0000_1400, 8'd1},
        {2'd0, 1'b0, 1'b1, 32'h0000_1005, 32'h0000_1408, 8'd3},
        {2'd1, 1'b0, 1'b0, 32'h0000_0F10, 32'h0000_1210, 8'd2},
        {2'd2, 1'b0, 1'b1, 32'h0000_2000, 32'h0000_2900, 8'd6},
        {2'd2, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_2900, 8'd3},
        {2'd1, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_2900, 8'd0},
        {2'd0, 1'b0, 1'b0, 32'h0000_3005, 32'h0000_300A, 8'd1},
        {2'd0, 1'b0, 1'b0, 32'h0000_3000, 32'h0000_3000, 8'd0},
        {2'd1, 1'b0, 1'b1, 32'h0000_3004, 32'h0000_3008, 8'd1},
        {2'd0, 1'b0, 1'b1, 32'h0000_4010, 32'h0000_5030, 8'd7},
        {2'd0, 1'b0, 1'b0, 32'h0000_7FE0, 32'h0000_8000, 8'd1},
        {2'd3, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001, 8'd2}
    };

    logic [1:0]  ek [MAXC];
    longint      ef [MAXC];
    longint      el [MAXC];
    int          en;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input longint f, input longint l);
        if (en < MAXC) begin
            ek[en] = k; ef[en] = f; el[en] = l;
        end
        en++;
    endtask

    function automatic longint chunk_end(longint s, longint e);
        longint c;
        c = e;
        if (s + 1024 < c) c = s + 1024;
        if ((s | 4095) + 1 < c) c = (s | 4095) + 1;
        return c;
    endfunction

    // Expected command list built from R1-style rules independently of the RTL.
    task automatic build_exp(input logic [1:0] op, input logic wt, input longint s, input longint e);
        longint ss, ee, c;
        en = 0;
        if (s == e) return;
        if (op == 2'd0) begin
            ss = s; ee = e;
            if (s % 32 != 0) begin
                push(2'd0, s - (s % 32), s - (s % 32));
                ss = s - (s % 32) + 32;
            end
            if (ss < e && e % 32 != 0) begin
                push(2'd0, e - (e % 32), e - (e % 32));
                ee = e - (e % 32);
            end
            while (ss < ee) begin
                c = chunk_end(ss, ee);
                push(2'd2, ss, c - 32);
                ss = c;
            end
        end else begin
            ss = s - (s % 32);
            ee = (e % 32 != 0) ? e - (e % 32) + 32 : e;
            if (op == 2'd1 && wt) return;
            while (ss < ee) begin
                c = chunk_end(ss, ee);
                if (!wt) push(2'd1, ss, c - 32);
                if (op != 2'd1) push(2'd2, ss, c - 32);
                ss = c;
            end
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic wt, input logic bp,
                           input logic [31:0] s, input logic [31:0] e, input int exp_n);
        int idx;
        int due;
        bit seen_done;
        bit hold;
        logic [1:0] hk;
        logic [31:0] hf, hl;
        build_exp(op, wt, longint'(s), longint'(e));
        check(en == exp_n, "R9", "model count", en, exp_n);
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_op = op; req_wt = wt; req_start = s; req_end = e;
        cmd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (en > 0) check(req_ready == 1'b0, "R10", "busy after accept", req_ready, 0);
        idx = 0;
        due = (en == 0) ? 0 : -1;
        seen_done = 0;
        hold = 0;
        for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
            if (hold) begin
                check(cmd_valid && cmd_kind == hk && cmd_first == hf && cmd_last == hl,
                      "R10", "held command", {cmd_kind, cmd_first}, {hk, hf});
                hold = 0;
            end
            if (done || cyc == due)
                check(done == (cyc == due), "R9", "done timing", done, cyc == due);
            if (done) seen_done = 1;
            cmd_ready = bp ? (cyc % 3 != 1) : 1'b1;
            if (cmd_valid) begin
                if (idx < en && idx < MAXC) begin
                    check(cmd_kind == ek[idx], "R1", "kind", cmd_kind, ek[idx]);
                    check(longint'(cmd_first) == ef[idx], "R4 R6", "first", cmd_first, ef[idx]);
                    check(longint'(cmd_last) == el[idx], "R2 R3 R5", "last", cmd_last, el[idx]);
                end else begin
                    check(1'b0, "R8", "extra command", idx, en);
                end
                if (cmd_ready) begin
                    idx++;
                    if (idx == en) due = cyc + 1;
                end else begin
                    hold = 1; hk = cmd_kind; hf = cmd_first; hl = cmd_last;
                end
            end
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        check(seen_done, "R9", "done seen", seen_done, 1);
        check(idx == en, "R7", "command count", idx, en);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R10",
              "reset state", {req_ready, cmd_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R10", "after reset", {req_ready, cmd_valid}, 2'b10);

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][75:74], VEC[v][73], VEC[v][72], VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]));
        end

        // Directed corner cases
        run_req(2'd2, 1'b0, 1'b1, 32'h0000_6FE4, 32'h0000_7004, 4);  // R3 flush across a page
        run_req(2'd0, 1'b0, 1'b1, 32'h0000_A004, 32'h0000_A03C, 2);  // R5 head and tail, no range
        run_req(2'd1, 1'b1, 1'b0, 32'h0000_B000, 32'h0000_C000, 0);  // R8 clean ignored under override
        run_req(2'd0, 1'b0, 1'b0, 32'h0000_D000, 32'h0000_E000, 4);  // R2 full page in four chunks
        run_req(2'd2, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0004, 0);  // R9 empty request

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule